// File: doc/BRIEF.md
# Spare Rank Remap Controller

This block looks after one standby chip-select on a memory node. Software uses a small control interface to name a failing chip-select. If sparing is enabled and the request is valid, a copy sequencer moves every line of that chip-select to the reserved spare, one line per copy command. It uses only the cycles in which no ordinary request is present. Ordinary reads and writes keep flowing through the block while the copy runs. The block issues these requests and the copy commands on a single command port toward the DRAM controller.

During the copy, a write to a line that has already been moved goes to both the failing chip-select and the spare. A write to a line not yet moved goes to the failing chip-select only, because the sequencer will carry it over later. Once every line has been copied, the block enters a done state. From then until reset, every access aimed at the failing chip-select is steered to the spare.

Top module: `spare_remap_ctrl`

## Requirements
- R1: After reset, `status_o` is 0 (idle) and `err_o` is 0. With no request present, `cmd_valid_o` is 0.
- R2: While no migration has been accepted, every request is forwarded in the same cycle with unchanged chip-select and line, and `cmd_mirror_o` is 0. The opcode is 0 for a read (`req_we_i`=0) and 1 for a write.
- R3: A migration request is accepted when all of the following hold: the status is idle, `spare_en_i` is 1, `mig_cs_i` differs from `spare_cs_i`, and bit `mig_cs_i` of `cs_en_i` is 1. From the next cycle, the status is 1 (copying) and `err_o` is 0.
- R4: A migration request is rejected if sparing is disabled, if it names the spare, or if it names a chip-select that is not enabled. After a rejection, `err_o` is 1, the status stays idle, and forwarding stays unchanged.
- R5: An ordinary request always takes priority over the copy. In any cycle with `req_valid_i` high, the command is the forwarded request and never a copy.
- R6: During copying, each cycle without an ordinary request issues one copy command (opcode 2). Its `cmd_cs_o` is the failing chip-select and its `cmd_dst_cs_o` is the spare. Copy commands visit lines 0 to LINES-1 in ascending order, each line once.
- R7: In the cycle after the copy of line LINES-1 is issued, the status becomes 2 (done).
- R8: During copying, a write to the failing chip-select at a line below the next line to be copied has `cmd_mirror_o`=1 and `cmd_dst_cs_o` equal to the spare. Any other write, and every read, has `cmd_mirror_o`=0.
- R9: In the done state, a request to the failing chip-select leaves with `cmd_cs_o` equal to the spare. Requests to any other chip-select are unchanged.
- R10: A migration request made while copying is ignored and sets `err_o` to 1. The failing chip-select, the copy order and the status are unaffected.
- R11: A migration request made in the done state is refused and sets `err_o` to 1. The redirection stays in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spare_en_i | input | 1 | Sparing enabled by configuration |
| spare_cs_i | input | CS_W | Chip-select reserved as the spare |
| cs_en_i | input | NUM_CS | Enabled chip-selects, one bit each |
| mig_req_i | input | 1 | Migration request strobe |
| mig_cs_i | input | CS_W | Failing chip-select named by the request |
| req_valid_i | input | 1 | Ordinary request present |
| req_we_i | input | 1 | Ordinary request is a write |
| req_cs_i | input | CS_W | Chip-select of the ordinary request |
| req_line_i | input | LINE_W | Line of the ordinary request |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 2 | 0 read, 1 write, 2 copy |
| cmd_cs_o | output | CS_W | Target chip-select (copy source for opcode 2) |
| cmd_line_o | output | LINE_W | Line address |
| cmd_mirror_o | output | 1 | Write also goes to `cmd_dst_cs_o` |
| cmd_dst_cs_o | output | CS_W | Spare for copy and mirrored writes, else 0 |
| status_o | output | 2 | 0 idle, 1 copying, 2 done |
| err_o | output | 1 | Last migration request was refused |

## Verification
The hardest case to reach is a write that lands on the failing chip-select during the copy. It must be checked on both sides of the moving copy pointer, and at the same time as a second migration request. The pointer advances only in cycles without ordinary traffic. The stimulus therefore interleaves request and idle cycles in a fixed rhythm and walks write lines through a stride that is coprime to the line count, so each write falls sometimes below and sometimes at or above the pointer. A behavioural model tracks the pointer and predicts, every cycle, whether the write is mirrored.

// File: rtl/spare_pkg.sv
package spare_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_DONE = 2'd2
  } spare_state_e;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_COPY = 2'd2
  } cmd_op_e;
endpackage

// File: rtl/spare_ctrl.sv
module spare_ctrl import spare_pkg::*; #(
  parameter int NUM_CS = 8,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spare_en_i,
  input  logic [CS_W-1:0]   spare_cs_i,
  input  logic [NUM_CS-1:0] cs_en_i,
  input  logic              mig_req_i,
  input  logic [CS_W-1:0]   mig_cs_i,
  input  logic              copy_last_i,
  output spare_state_e      state_o,
  output logic [CS_W-1:0]   bad_cs_o,
  output logic              start_o,
  output logic              err_o
);
  logic accept;

  assign accept  = mig_req_i && (state_o == ST_IDLE) && spare_en_i &&
                   (mig_cs_i != spare_cs_i) && cs_en_i[mig_cs_i];
  assign start_o = accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= ST_IDLE;
      bad_cs_o <= '0;
      err_o    <= 1'b0;
    end else begin
      if (accept) begin
        state_o  <= ST_COPY;
        bad_cs_o <= mig_cs_i;
        err_o    <= 1'b0;
      end else begin
        if (mig_req_i) err_o <= 1'b1;
        if (state_o == ST_COPY && copy_last_i) state_o <= ST_DONE;
      end
    end
  end
endmodule

// File: rtl/spare_copy_seq.sv
module spare_copy_seq #(
  parameter int LINES = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              busy_i,
  output logic              grant_o,
  output logic [LINE_W-1:0] ptr_o,
  output logic              last_o
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LINES - 1);

  // copy only steals cycles the host leaves empty
  assign grant_o = active_i && !busy_i;
  assign last_o  = grant_o && (ptr_o == LastLine);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (start_i) ptr_o <= '0;
    else if (grant_o) ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/spare_redirect.sv
module spare_redirect import spare_pkg::*; #(
  parameter int NUM_CS = 8,
  parameter int LINES  = 16,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  spare_state_e      state_i,
  input  logic [CS_W-1:0]   bad_cs_i,
  input  logic [CS_W-1:0]   spare_cs_i,
  input  logic [LINE_W-1:0] ptr_i,
  input  logic              grant_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [CS_W-1:0]   cmd_cs_o,
  output logic [LINE_W-1:0] cmd_line_o,
  output logic              cmd_mirror_o,
  output logic [CS_W-1:0]   cmd_dst_cs_o
);
  logic hit_bad;
  assign hit_bad = (req_cs_i == bad_cs_i);

  always_comb begin
    cmd_valid_o  = 1'b0;
    cmd_op_o     = OP_RD;
    cmd_cs_o     = '0;
    cmd_line_o   = '0;
    cmd_mirror_o = 1'b0;
    cmd_dst_cs_o = '0;
    if (grant_i) begin
      cmd_valid_o  = 1'b1;
      cmd_op_o     = OP_COPY;
      cmd_cs_o     = bad_cs_i;
      cmd_line_o   = ptr_i;
      cmd_dst_cs_o = spare_cs_i;
    end else if (req_valid_i) begin
      cmd_valid_o = 1'b1;
      cmd_op_o    = req_we_i ? OP_WR : OP_RD;
      cmd_line_o  = req_line_i;
      cmd_cs_o    = (state_i == ST_DONE && hit_bad) ? spare_cs_i : req_cs_i;
      // already-copied lines must stay coherent in the spare
      if (state_i == ST_COPY && req_we_i && hit_bad && req_line_i < ptr_i) begin
        cmd_mirror_o = 1'b1;
        cmd_dst_cs_o = spare_cs_i;
      end
    end
  end
endmodule

// File: rtl/spare_remap_ctrl.sv
module spare_remap_ctrl import spare_pkg::*; #(
  parameter int NUM_CS = 8,
  parameter int LINES  = 16,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spare_en_i,
  input  logic [CS_W-1:0]   spare_cs_i,
  input  logic [NUM_CS-1:0] cs_en_i,
  input  logic              mig_req_i,
  input  logic [CS_W-1:0]   mig_cs_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [CS_W-1:0]   cmd_cs_o,
  output logic [LINE_W-1:0] cmd_line_o,
  output logic              cmd_mirror_o,
  output logic [CS_W-1:0]   cmd_dst_cs_o,
  output logic [1:0]        status_o,
  output logic              err_o
);
  spare_state_e      state;
  logic [CS_W-1:0]   bad_cs;
  logic [LINE_W-1:0] ptr;
  logic              start, grant, last;

  spare_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
    .clk_i, .rst_ni, .spare_en_i, .spare_cs_i, .cs_en_i, .mig_req_i, .mig_cs_i,
    .copy_last_i(last), .state_o(state), .bad_cs_o(bad_cs), .start_o(start),
    .err_o
  );

  spare_copy_seq #(.LINES(LINES)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .active_i(state == ST_COPY),
    .busy_i(req_valid_i), .grant_o(grant), .ptr_o(ptr), .last_o(last)
  );

  spare_redirect #(.NUM_CS(NUM_CS), .LINES(LINES)) u_redir (
    .state_i(state), .bad_cs_i(bad_cs), .spare_cs_i, .ptr_i(ptr),
    .grant_i(grant), .req_valid_i, .req_we_i, .req_cs_i, .req_line_i,
    .cmd_valid_o, .cmd_op_o, .cmd_cs_o, .cmd_line_o, .cmd_mirror_o,
    .cmd_dst_cs_o
  );

  assign status_o = state;
endmodule

// File: rtl/spare_remap_sva.sv
module spare_remap_sva #(
  parameter int NUM_CS = 8,
  parameter int LINES  = 16,
  localparam int CS_W   = $clog2(NUM_CS),
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CS_W-1:0]   spare_cs_i,
  input logic              mig_req_i,
  input logic              req_valid_i,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_op_o,
  input logic [CS_W-1:0]   cmd_cs_o,
  input logic [LINE_W-1:0] cmd_line_o,
  input logic              cmd_mirror_o,
  input logic [CS_W-1:0]   cmd_dst_cs_o,
  input logic [1:0]        status_o,
  input logic              err_o,
  input logic [CS_W-1:0]   bad_cs
);
  logic [LINE_W:0] n_copies;
  logic            is_copy;
  assign is_copy = cmd_valid_o && cmd_op_o == 2'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                n_copies <= '0;
    else if (status_o == 2'd0)  n_copies <= '0;
    else if (is_copy)           n_copies <= n_copies + 1'b1;
  end

  a_r1_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);

  a_r5_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> cmd_valid_o && cmd_op_o != 2'd2);

  a_r6_copy_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_copy |-> status_o == 2'd1 && cmd_line_o == n_copies[LINE_W-1:0] &&
                cmd_cs_o == bad_cs && cmd_dst_cs_o == spare_cs_i);

  a_r7_done_after_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o == 2'd2) |-> n_copies == (LINE_W+1)'(LINES));

  a_r8_mirror_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_mirror_o |-> status_o == 2'd1 && cmd_op_o == 2'd1 &&
                     cmd_cs_o == bad_cs && cmd_dst_cs_o == spare_cs_i);

  a_r9_no_bad_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd2 && cmd_valid_o && bad_cs != spare_cs_i |-> cmd_cs_o != bad_cs);

  a_r10_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd1 && mig_req_i |=> err_o && status_o != 2'd0 && $stable(bad_cs));

  a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'd2 |=> status_o == 2'd2 && $stable(bad_cs));
endmodule

bind spare_remap_ctrl spare_remap_sva #(.NUM_CS(NUM_CS), .LINES(LINES)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .spare_cs_i(spare_cs_i), .mig_req_i(mig_req_i),
  .req_valid_i(req_valid_i), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
  .cmd_cs_o(cmd_cs_o), .cmd_line_o(cmd_line_o), .cmd_mirror_o(cmd_mirror_o),
  .cmd_dst_cs_o(cmd_dst_cs_o), .status_o(status_o), .err_o(err_o), .bad_cs(bad_cs)
);

// File: tb/spare_remap_ctrl_bench.sv
module spare_remap_ctrl_bench;
  localparam int NUM_CS = 8;
  localparam int LINES  = 16;
  localparam int CS_W   = $clog2(NUM_CS);
  localparam int LINE_W = $clog2(LINES);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic spare_en_i = 1'b0;
  logic [CS_W-1:0] spare_cs_i = '0;
  logic [NUM_CS-1:0] cs_en_i = '0;
  logic mig_req_i = 1'b0;
  logic [CS_W-1:0] mig_cs_i = '0;
  logic req_valid_i = 1'b0;
  logic req_we_i = 1'b0;
  logic [CS_W-1:0] req_cs_i = '0;
  logic [LINE_W-1:0] req_line_i = '0;
  logic cmd_valid_o, cmd_mirror_o, err_o;
  logic [1:0] cmd_op_o, status_o;
  logic [CS_W-1:0] cmd_cs_o, cmd_dst_cs_o;
  logic [LINE_W-1:0] cmd_line_o;

  always #4 clk_i = ~clk_i;

  spare_remap_ctrl #(.NUM_CS(NUM_CS), .LINES(LINES)) u_spare_remap_ctrl (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  // reference model state
  int m_state = 0, m_bad = 0, m_ptr = 0, m_err = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    int e_valid, e_op, e_cs, e_line, e_mir, e_dst, old_state;
    bit grant;
    @(negedge clk_i);
    grant = (m_state == 1) && !req_valid_i;
    e_valid = 0; e_op = 0; e_cs = 0; e_line = 0; e_mir = 0; e_dst = 0;
    if (grant) begin
      e_valid = 1; e_op = 2; e_cs = m_bad; e_line = m_ptr; e_dst = int'(spare_cs_i);
    end else if (req_valid_i) begin
      e_valid = 1; e_op = req_we_i ? 1 : 0; e_line = int'(req_line_i);
      e_cs = (m_state == 2 && int'(req_cs_i) == m_bad) ? int'(spare_cs_i) : int'(req_cs_i);
      if (m_state == 1 && req_we_i && int'(req_cs_i) == m_bad && int'(req_line_i) < m_ptr) begin
        e_mir = 1; e_dst = int'(spare_cs_i);
      end
    end
    chk(tag, "valid", int'(cmd_valid_o), e_valid);
    if (e_valid == 1) begin
      chk(tag, "op", int'(cmd_op_o), e_op);
      chk(tag, "cs", int'(cmd_cs_o), e_cs);
      chk(tag, "line", int'(cmd_line_o), e_line);
      chk(tag, "mirror", int'(cmd_mirror_o), e_mir);
      chk(tag, "dst", int'(cmd_dst_cs_o), e_dst);
    end
    chk(tag, "status", int'(status_o), m_state);
    chk(tag, "err", int'(err_o), m_err);
    // model update for the coming edge
    old_state = m_state;
    if (grant) begin
      if (m_ptr == LINES - 1) m_state = 2;
      m_ptr++;
    end
    if (mig_req_i) begin
      if (old_state == 0 && spare_en_i && mig_cs_i != spare_cs_i && cs_en_i[mig_cs_i]) begin
        m_state = 1; m_bad = int'(mig_cs_i); m_ptr = 0; m_err = 0;
      end else m_err = 1;
    end
    @(posedge clk_i);
    #1;
  endtask

  task automatic host(input bit v, input bit we, input int cs, input int line);
    req_valid_i = v; req_we_i = we;
    req_cs_i = CS_W'(cs); req_line_i = LINE_W'(line);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    spare_en_i = 1'b1; spare_cs_i = 3'd7; cs_en_i = 8'h7F;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc("R1"); cyc("R1");

    // R2: plain forwarding before any migration
    for (int i = 0; i < 8; i++) begin
      host(1'b1, i[0], i, i * 3);
      cyc("R2");
    end
    host(1'b0, 1'b0, 0, 0);

    // R4: three kinds of refused request
    spare_en_i = 1'b0; mig_req_i = 1'b1; mig_cs_i = 3'd1; cyc("R4");
    spare_en_i = 1'b1; mig_req_i = 1'b0; host(1'b1, 1'b1, 1, 5); cyc("R4");
    host(1'b0, 1'b0, 0, 0);
    mig_req_i = 1'b1; mig_cs_i = 3'd7; cyc("R4");
    cs_en_i = 8'h7B; mig_cs_i = 3'd2; cyc("R4");
    mig_req_i = 1'b0; cs_en_i = 8'h7F; host(1'b1, 1'b0, 2, 9); cyc("R4");
    host(1'b0, 1'b0, 0, 0);

    // R3: accepted request clears the error flag
    mig_req_i = 1'b1; mig_cs_i = 3'd2; cyc("R3");
    mig_req_i = 1'b0; host(1'b1, 1'b1, 2, 0); cyc("R3");

    // R5 R6 R8 R10: mixed traffic during the copy
    for (int k = 0; k < 100 && m_state == 1; k++) begin
      bit v, we;
      int cs;
      v  = (k % 3) != 0;
      we = (k % 2) == 1;
      cs = ((k % 4) < 2) ? 2 : (k % 7);
      host(v, we, cs, (k * 5) % LINES);
      mig_req_i = (k == 10 || k == 25); mig_cs_i = 3'd3;
      if (mig_req_i) cyc("R10");
      else if (!v) cyc("R6");
      else if (we && cs == 2) cyc("R8");
      else cyc("R5");
    end
    mig_req_i = 1'b0; host(1'b0, 1'b0, 0, 0);
    chk("R7", "model_done", m_state, 2);
    cyc("R7"); cyc("R7");

    // R9: redirection of the failing chip-select only
    for (int i = 0; i < 8; i++) begin
      host(1'b1, i[1], i, 15 - i);
      cyc("R9");
    end
    host(1'b0, 1'b0, 0, 0);

    // R11: second migration refused, redirect unchanged
    mig_req_i = 1'b1; mig_cs_i = 3'd4; cyc("R11");
    mig_req_i = 1'b0; host(1'b1, 1'b1, 2, 3); cyc("R11");
    host(1'b1, 1'b0, 4, 6); cyc("R11");
    host(1'b0, 1'b0, 0, 0); cyc("R11");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule